// File: doc/BRIEF.md
# Redundant-Digit Correction for a 1.5-bit-per-Stage Pipelined Converter

This block turns the raw decisions of a pipelined analog-to-digital converter into one binary sample word. The converter front end has `N_RED` redundant stages and a final 2-bit flash stage. Each redundant stage compares its input against two thresholds and reports one of three decisions. The final stage reports one of four. The analog pipeline produces the decisions for one sample one beat apart. On any beat, the field belonging to stage k therefore carries the decision for the sample that entered stage 0 k beats earlier.

Inside the block, each stage's digit is delayed so that all digits of one sample meet. The aligned digits are then added, with each redundant stage weighted one bit above its successor so that adjacent stages overlap by one bit. A comparator whose threshold is misplaced by less than a quarter of the reference pushes an error into the residue. The following stage then absorbs that error, so the sum still equals the error-free quantisation.

Both edges of the block are valid/ready streams. An input beat transfers on a clock edge where `in_valid` and `in_ready` are both high. An output word transfers where `out_valid` and `out_ready` are both high. While an output word waits, it stays unchanged and the block accepts no input. The upstream source must hold its beat until it is accepted. Alignment counts accepted beats, not clock cycles.

Top module: `rdc_correction`

## Requirements
- R1: Stage k's decision sits in `red_codes[2k+1:2k]`, with stage 0 the first stage. Code 00 means below the lower threshold and counts as digit 0. Code 01 means between the thresholds and counts as digit 1. Code 10 means above the upper threshold and counts as digit 2. `fine_code` is the final flash result, read as an unsigned number from 0 to 3.
- R2: For one sample, `out_word` equals `fine + sum over k of digit_k * 2^(N_RED-k)`, as an unsigned word of `N_RED+2` bits.
- R3: Field k of the accepted beat b belongs to sample b-k, and `fine_code` of beat b belongs to sample b-N_RED. The word for sample n is presented with `out_valid` in the cycle after beat n+N_RED is accepted.
- R4: After reset, the first N_RED accepted beats yield no output word. From then on, each accepted beat yields exactly one output word, in sample order, and no word appears without an accepted beat.
- R5: A redundant-stage code of 11 is treated exactly like 10.
- R6: During and right after reset, `out_valid` is low and `in_ready` is high.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_word` keeps its value.
- R8: `in_ready` is high exactly when no word is held or the held word is being taken in the same cycle. A cycle with `in_valid` low advances nothing.
- R9: Suppose every redundant-stage threshold lies within ±Vref/4 of its nominal value of ±Vref/4, and the final flash is ideal. Then `out_word` equals floor((Vin+Vref)·2^(N_RED+1)/Vref) for every Vin in [−Vref, Vref).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat this cycle |
| red_codes | input | 2*N_RED | Packed three-level decisions of the redundant stages |
| fine_code | input | 2 | Final 2-bit stage decision |
| out_valid | output | 1 | Corrected word present |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_word | output | N_RED+2 | Corrected binary sample |

## Verification
The hardest case to reach from the ports is the one where cancellation actually does the work. That needs a sample that lands between a shifted threshold and its nominal position, where a wrong stage decision must be repaired by the stages after it. The bench reaches this case with a behavioural residue model in real arithmetic. The model places every comparator threshold off-nominal by up to 3/16 of the reference, then sweeps dyadic inputs finely enough to cross every shifted threshold. It skews the resulting decisions into beats exactly as an analog pipeline would, and compares the outputs against the ideal quantisation. Valid gaps and long ready stalls in the same streams show that the alignment follows accepted beats rather than cycles.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
  typedef logic [1:0] dec_t;

  localparam dec_t DEC_BELOW   = 2'b00;
  localparam dec_t DEC_MIDDLE  = 2'b01;
  localparam dec_t DEC_ABOVE   = 2'b10;
  localparam dec_t DEC_ILLEGAL = 2'b11;

  // Map a three-level stage decision onto its digit value 0..2.
  function automatic dec_t rdc_digit(input dec_t c);
    return (c == DEC_ILLEGAL) ? DEC_ABOVE : c;
  endfunction
endpackage

// File: rtl/rdc_delay_line.sv
module rdc_delay_line #(
  parameter int WIDTH = 2,
  parameter int DEPTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign q = d;
    end else begin : g_shift
      logic [WIDTH-1:0] sr [DEPTH];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
        end else if (en) begin
          sr[0] <= d;
          for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
        end
      end

      assign q = sr[DEPTH-1];

      // Alignment counts accepted beats only; an idle cycle must freeze the tap.
      AST_DELAY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q)); // R3
    end
  endgenerate
endmodule

// File: rtl/rdc_digit_align.sv
module rdc_digit_align
  import rdc_pkg::*;
#(
  parameter int N_RED = 3,
  localparam int IN_W = 2 * N_RED
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [IN_W-1:0] red_codes,
  input  logic [1:0]      fine_code,
  output logic [IN_W-1:0] dig_aligned,
  output logic [1:0]      fine_aligned
);
  genvar k;
  generate
    for (k = 0; k < N_RED; k++) begin : g_stage
      dec_t raw_dig;
      assign raw_dig = rdc_digit(red_codes[2*k +: 2]);

      // Stage k is N_RED-k beats ahead of the final stage for the same sample.
      rdc_delay_line #(.WIDTH(2), .DEPTH(N_RED - k)) u_dl (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .d    (raw_dig),
        .q    (dig_aligned[2*k +: 2])
      );
    end
  endgenerate

  assign fine_aligned = fine_code;
endmodule

// File: rtl/rdc_overlap_sum.sv
module rdc_overlap_sum #(
  parameter int N_RED = 3,
  localparam int IN_W  = 2 * N_RED,
  localparam int OUT_W = N_RED + 2
) (
  input  logic [IN_W-1:0]  dig,
  input  logic [1:0]       fine,
  output logic [OUT_W-1:0] total
);
  logic [OUT_W-1:0] part [N_RED+1];

  assign part[0] = OUT_W'(fine);

  genvar k;
  generate
    for (k = 0; k < N_RED; k++) begin : g_add
      // One bit of overlap: stage k weighs 2^(N_RED-k), its successor half of that.
      assign part[k+1] = part[k] + (OUT_W'(dig[2*k +: 2]) << (N_RED - k));

      always_comb begin
        AST_DIGIT_LEGAL: assert (dig[2*k +: 2] !== 2'b11); // R5
      end
    end
  endgenerate

  assign total = part[N_RED];
endmodule

// File: rtl/rdc_correction.sv
module rdc_correction #(
  parameter int N_RED = 3,
  localparam int IN_W   = 2 * N_RED,
  localparam int OUT_W  = N_RED + 2,
  localparam int FILL_W = $clog2(N_RED + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  red_codes,
  input  logic [1:0]       fine_code,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_word
);
  logic              accept;
  logic              primed;
  logic [FILL_W-1:0] fill_q;
  logic [IN_W-1:0]   dig_aligned;
  logic [1:0]        fine_aligned;
  logic [OUT_W-1:0]  sum_w;
  logic              ov_q;
  logic [OUT_W-1:0]  ow_q;

  assign in_ready = !ov_q || out_ready;
  assign accept   = in_valid && in_ready;
  assign primed   = (fill_q == FILL_W'(N_RED));

  rdc_digit_align #(.N_RED(N_RED)) u_align (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (accept),
    .red_codes   (red_codes),
    .fine_code   (fine_code),
    .dig_aligned (dig_aligned),
    .fine_aligned(fine_aligned)
  );

  rdc_overlap_sum #(.N_RED(N_RED)) u_sum (
    .dig  (dig_aligned),
    .fine (fine_aligned),
    .total(sum_w)
  );

  // Beats before the pipe is primed carry no complete sample.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q <= '0;
    end else if (accept && !primed) begin
      fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      ow_q <= '0;
    end else if (in_ready) begin
      ov_q <= accept && primed;
      if (accept && primed) ow_q <= sum_w;
    end
  end

  assign out_valid = ov_q;
  assign out_word  = ow_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word)); // R7
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R8
  AST_WORD_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R4
  AST_WORD_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> primed); // R4
  AST_TAKEN_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid); // R8
endmodule

// File: tb/tb_rdc_correction.sv
module tb_rdc_correction;
  localparam int NR   = 3;
  localparam int W    = NR + 2;
  localparam int MAXS = 160;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [2*NR-1:0] red_codes = '0;
  logic [1:0]    fine_code = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [W-1:0]  out_word;

  int n_chk = 0;
  int n_bad = 0;

  int  dig_of [MAXS][NR];
  int  fin_of [MAXS];
  int  exp_of [MAXS];
  int  nsamp;
  real off_hi [NR];
  real off_lo [NR];

  always #5 clk = ~clk;

  rdc_correction #(.N_RED(NR)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .red_codes(red_codes), .fine_code(fine_code), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic set_offsets(input real h0, input real h1, input real h2,
                             input real l0, input real l1, input real l2);
    off_hi[0] = h0; off_hi[1] = h1; off_hi[2] = h2;
    off_lo[0] = l0; off_lo[1] = l1; off_lo[2] = l2;
  endtask

  // Behavioural residue chain with offset thresholds; ideal final flash.
  task automatic model(input real vin, input int idx);
    real v;
    int  e;
    v = vin;
    for (int k = 0; k < NR; k++) begin
      if (v > 0.25 + off_hi[k]) begin
        dig_of[idx][k] = 2; v = 2.0 * v - 1.0;
      end else if (v < -0.25 + off_lo[k]) begin
        dig_of[idx][k] = 0; v = 2.0 * v + 1.0;
      end else begin
        dig_of[idx][k] = 1; v = 2.0 * v;
      end
    end
    fin_of[idx] = (v < -0.5) ? 0 : (v < 0.0) ? 1 : (v < 0.5) ? 2 : 3;
    e = int'($floor((vin + 1.0) * real'(1 << (W - 1))));
    if (e < 0) e = 0;
    if (e > (1 << W) - 1) e = (1 << W) - 1;
    exp_of[idx] = e;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R6 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R6 in_ready after reset", int'(in_ready), 1);
  endtask

  // mode 0: free flow; 1: valid gaps and ready gaps; 2: long ready stall.
  task automatic run_stream(input int mode, input bit illegal, input string req);
    int b = 0, got = 0, cyc = 0;
    bit pend = 1'b0;
    logic [W-1:0] held = '0;
    while (got < nsamp && cyc < 3000) begin
      @(negedge clk);
      if (pend) chk(out_valid && out_word == held, "R7 held word", int'(out_word), int'(held));
      case (mode)
        1: out_ready = (cyc % 3) != 0;
        2: out_ready = !(cyc >= 6 && cyc < 26);
        default: out_ready = 1'b1;
      endcase
      if (b < nsamp + NR) begin
        in_valid = (mode == 1) ? ((cyc % 4) != 1) : 1'b1;
        for (int k = 0; k < NR; k++) begin
          int s, dv;
          s  = b - k;
          dv = (s >= 0 && s < nsamp) ? dig_of[s][k] : 1;
          if (illegal && dv == 2 && (b % 2) == 1) dv = 3;  // R5: code 11 stands in for 10
          red_codes[2*k +: 2] = 2'(dv);
        end
        fine_code = (b - NR >= 0 && b - NR < nsamp) ? 2'(fin_of[b - NR]) : 2'd0;
      end else begin
        in_valid = 1'b0;
      end
      #1;
      if (out_valid && out_ready) begin
        chk(out_word == W'(exp_of[got]), req, int'(out_word), exp_of[got]);
        got++;
      end
      pend = out_valid && !out_ready;
      held = out_word;
      if (out_valid && !out_ready)
        chk(in_ready == 1'b0, "R8 in_ready during stall", int'(in_ready), 0);
      if (in_valid && in_ready) b++;
      cyc++;
    end
    chk(got == nsamp, "R4 word count", got, nsamp);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (4) begin
      @(negedge clk); #1;
      chk(out_valid == 1'b0, "R4 no word without beat", int'(out_valid), 0);
    end
  endtask

  task automatic t_ideal_sweep();
    do_reset();
    set_offsets(0.0, 0.0, 0.0, 0.0, 0.0, 0.0);
    nsamp = 1 << W;
    for (int i = 0; i < nsamp; i++) model(-1.0 + real'(2 * i + 1) / real'(1 << W), i);
    run_stream(0, 1'b0, "R1 R2 R3 ideal sweep");
  endtask

  task automatic t_offset_sweep();
    do_reset();
    set_offsets(0.1875, -0.125, 0.0625, -0.1875, 0.125, -0.0625);
    nsamp = 128;
    for (int j = 0; j < nsamp; j++) model(-1.0 + real'(2 * j + 1) / 128.0, j);
    run_stream(1, 1'b0, "R9 offsets with gaps");
  endtask

  task automatic t_extremes();
    do_reset();
    set_offsets(-0.1875, 0.1875, -0.1875, 0.1875, -0.1875, 0.1875);
    nsamp = 6;
    model(-1.0, 0);
    model(1.0 - 1.0 / 1024.0, 1);
    model(0.0625, 2);
    model(-0.0625, 3);
    model(0.0, 4);
    model(0.4375, 5);
    run_stream(0, 1'b0, "R9 extremes");
    chk(exp_of[0] == 0 && exp_of[1] == (1 << W) - 1, "R9 range ends", exp_of[1], (1 << W) - 1);
  endtask

  task automatic t_illegal_code();
    do_reset();
    set_offsets(0.125, 0.0, -0.125, 0.0, -0.125, 0.125);
    nsamp = 64;
    for (int i = 0; i < nsamp; i++) model(-1.0 + real'(2 * i + 1) / 64.0, i);
    run_stream(0, 1'b1, "R5 code 11 as 10");
  endtask

  task automatic t_stall();
    do_reset();
    set_offsets(0.0625, 0.1875, -0.1875, -0.125, 0.0625, 0.1875);
    nsamp = 40;
    for (int i = 0; i < nsamp; i++) model(-1.0 + real'(4 * i + 1) / 80.0, i);
    run_stream(2, 1'b0, "R7 R3 long stall");
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_ideal_sweep();
    t_offset_sweep();
    t_extremes();
    t_illegal_code();
    t_stall();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule